// File: doc/BRIEF.md
# Masked Calendar Alarm Comparator

This block keeps two alarm register sets and compares each one against the running BCD calendar. Each set has six compared fields: seconds, minutes, hours, date, month and day of week. Every field register carries an enable flag in its top bit and a 7-bit value below it. A comparison runs on each one-second update strobe, which the calendar raises once it has advanced. An alarm matches when at least one of its fields is enabled and every enabled field equals the calendar. A match latches a sticky flag.

The two flags appear on their own outputs. They also appear inside a status byte, together with four status bits that come from elsewhere in the chip (battery supply, register-write latch, write latch, clock-fail). A status read is signalled by two pulses: one when the read begins and one at its last data bit. The second pulse clears only the flags that were already set when the first pulse arrived, so an alarm that fires during the read is not lost. Alarm registers are loaded through a simple write port. The year register slot is accepted but takes no part in matching.

Top module: `cal_alarm_match`

## Requirements
- R1: In the cycle after a synchronous reset both flags read 0, and every alarm field register is 0, so all fields are disabled.
- R2: A write loads `wr_data_i` into field `wr_field_i` of alarm `wr_alarm_i` (0 or 1). The field codes are 0 seconds, 1 minutes, 2 hours, 3 date, 4 month, 5 day of week, 6 year, 7 unused. Bit 7 of the data is the field's enable and bits 6:0 are its value.
- R3: Only enabled fields take part in a comparison. A disabled field's value and the matching calendar field have no effect.
- R4: An alarm whose six compared fields are all disabled never sets its flag.
- R5: Writes to field code 6 (year) or 7 change nothing observable in matching.
- R6: The hour comparison uses bits 6:0 only. Bit 7 of the calendar hour, the 24-hour mode bit, is ignored.
- R7: Matching is evaluated only in a cycle with `tick_i` high. A match sets the flag at that clock edge, so it is visible from the next cycle. If a register write lands in the same cycle, the comparison uses the old register contents.
- R8: A set flag stays set until a status read clears it.
- R9: `status_o` is {bat_i, AL1, AL0, 2'b00, rwel_i, wel_i, rtcf_i}, from bit 7 down to bit 0.
- R10: `sr_rd_done_i` clears only the flags that were set in the cycle `sr_rd_start_i` was seen. A start and a done in the same cycle clear the flags set at that moment. A done with no read open clears nothing.
- R11: A flag that becomes set during an open read, including in the done cycle itself, remains set after the read. Matching continues throughout the read.
- R12: The two alarms match and flag independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-second update strobe; the calendar inputs are valid while it is high |
| cal_sec_i | input | 8 | Calendar seconds, BCD |
| cal_min_i | input | 8 | Calendar minutes, BCD |
| cal_hour_i | input | 8 | Calendar hours, BCD; bit 7 is the 24-hour mode bit |
| cal_date_i | input | 8 | Calendar date, BCD |
| cal_mon_i | input | 8 | Calendar month, BCD |
| cal_dow_i | input | 8 | Calendar day of week |
| wr_en_i | input | 1 | Alarm register write strobe |
| wr_alarm_i | input | 1 | Alarm select for the write |
| wr_field_i | input | 3 | Field code for the write |
| wr_data_i | input | 8 | Write data: enable in bit 7, value in bits 6:0 |
| sr_rd_start_i | input | 1 | Status read begins |
| sr_rd_done_i | input | 1 | Last data bit of the status read |
| bat_i | input | 1 | Battery-supply status bit |
| rwel_i | input | 1 | Register write enable latch bit |
| wel_i | input | 1 | Write enable latch bit |
| rtcf_i | input | 1 | Clock-fail status bit |
| al0_o | output | 1 | Sticky flag of alarm 0 |
| al1_o | output | 1 | Sticky flag of alarm 1 |
| status_o | output | 8 | Formatted status byte |

## Verification
The bench builds the block with its default parameters: two alarms, six compared fields and a 7-bit field value. This is the only shape the status byte supports. Random field codes cover the year and unused slots. Calendar values are often copied from an alarm's own registers, so full matches, single-field mismatches and all-disabled sets all occur often. Random start and done pulses bring matches that land inside an open read, and coincident start/done cycles, within reach. Directed phases pin down the hour mode bit and the keep-while-reading rule.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;

    localparam int NUM_ALARMS = 2;
    localparam int NUM_FIELDS = 6;
    localparam int VAL_W      = 7;
    localparam int FIELD_W    = VAL_W + 1;
    localparam int SEL_W      = 3;
    localparam int AIDX_W     = (NUM_ALARMS > 1) ? $clog2(NUM_ALARMS) : 1;

    typedef enum logic [SEL_W-1:0] {
        FLD_SEC  = 3'd0,
        FLD_MIN  = 3'd1,
        FLD_HOUR = 3'd2,
        FLD_DATE = 3'd3,
        FLD_MON  = 3'd4,
        FLD_DOW  = 3'd5,
        FLD_YEAR = 3'd6,
        FLD_NONE = 3'd7
    } field_sel_e;

    typedef struct packed {
        logic             en;
        logic [VAL_W-1:0] val;
    } alarm_field_t;

    typedef alarm_field_t [NUM_FIELDS-1:0] alarm_set_t;
    typedef logic [NUM_FIELDS-1:0][VAL_W-1:0] cal_vec_t;

    typedef struct packed {
        logic       bat;
        logic       al1;
        logic       al0;
        logic [1:0] pad;
        logic       rwel;
        logic       wel;
        logic       rtcf;
    } status_t;

    function automatic logic field_passes(alarm_field_t f, logic [VAL_W-1:0] c);
        return (!f.en) || (f.val == c);
    endfunction

endpackage

// File: rtl/alarm_regfile.sv
module alarm_regfile
    import cal_alarm_pkg::*;
#(
    parameter int ALARM_ID = 0
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [AIDX_W-1:0]     wr_alarm,
    input  logic [SEL_W-1:0]      wr_field,
    input  logic [FIELD_W-1:0]    wr_data,
    output alarm_set_t            regs
);
    logic sel_me;
    assign sel_me = wr_en && (wr_alarm == AIDX_W'(ALARM_ID));

    for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[f] <= '0;
            end else if (sel_me && (wr_field == SEL_W'(f))) begin
                regs[f] <= alarm_field_t'(wr_data);
            end
        end
    end
endmodule

// File: rtl/alarm_matcher.sv
module alarm_matcher
    import cal_alarm_pkg::*;
(
    input  alarm_set_t regs,
    input  cal_vec_t   cal,
    output logic       hit
);
    logic [NUM_FIELDS-1:0] pass;
    logic [NUM_FIELDS-1:0] ens;

    for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_cmp
        assign pass[f] = field_passes(regs[f], cal[f]);
        assign ens[f]  = regs[f].en;
    end

    assign hit = (|ens) && (&pass);
endmodule

// File: rtl/alarm_flag_ctrl.sv
module alarm_flag_ctrl
    import cal_alarm_pkg::*;
#(
    parameter int N = NUM_ALARMS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic [N-1:0] hit,
    input  logic         rd_start,
    input  logic         rd_done,
    output logic [N-1:0] flags
);
    logic [N-1:0] snap_q;
    logic         open_q;
    logic [N-1:0] snap_eff;
    logic         open_eff;
    logic [N-1:0] clr;
    logic [N-1:0] set;

    always_comb begin
        snap_eff = rd_start ? flags : snap_q;
        open_eff = rd_start || open_q;
        clr      = (rd_done && open_eff) ? snap_eff : '0;
        set      = tick ? hit : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags  <= '0;
            snap_q <= '0;
            open_q <= 1'b0;
        end else begin
            flags  <= (flags & ~clr) | set;
            snap_q <= rd_done ? '0 : snap_eff;
            open_q <= open_eff && !rd_done;
        end
    end
endmodule

// File: rtl/cal_alarm_match.sv
module cal_alarm_match
    import cal_alarm_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               tick_i,
    input  logic [FIELD_W-1:0] cal_sec_i,
    input  logic [FIELD_W-1:0] cal_min_i,
    input  logic [FIELD_W-1:0] cal_hour_i,
    input  logic [FIELD_W-1:0] cal_date_i,
    input  logic [FIELD_W-1:0] cal_mon_i,
    input  logic [FIELD_W-1:0] cal_dow_i,
    input  logic               wr_en_i,
    input  logic               wr_alarm_i,
    input  logic [SEL_W-1:0]   wr_field_i,
    input  logic [FIELD_W-1:0] wr_data_i,
    input  logic               sr_rd_start_i,
    input  logic               sr_rd_done_i,
    input  logic               bat_i,
    input  logic               rwel_i,
    input  logic               wel_i,
    input  logic               rtcf_i,
    output logic               al0_o,
    output logic               al1_o,
    output logic [7:0]         status_o
);
    cal_vec_t                cal;
    alarm_set_t              aset [NUM_ALARMS];
    logic [NUM_ALARMS-1:0]   hit_vec;
    logic [NUM_ALARMS-1:0]   en_any_vec;
    logic [NUM_ALARMS-1:0]   flag_vec;
    status_t                 st;

    // Bit 7 of each calendar byte is dropped; for the hour this removes the mode bit.
    always_comb begin
        cal[FLD_SEC]  = cal_sec_i[VAL_W-1:0];
        cal[FLD_MIN]  = cal_min_i[VAL_W-1:0];
        cal[FLD_HOUR] = cal_hour_i[VAL_W-1:0];
        cal[FLD_DATE] = cal_date_i[VAL_W-1:0];
        cal[FLD_MON]  = cal_mon_i[VAL_W-1:0];
        cal[FLD_DOW]  = cal_dow_i[VAL_W-1:0];
    end

    for (genvar a = 0; a < NUM_ALARMS; a++) begin : g_alarm
        alarm_regfile #(.ALARM_ID(a)) u_regs (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (wr_en_i),
            .wr_alarm (AIDX_W'(wr_alarm_i)),
            .wr_field (wr_field_i),
            .wr_data  (wr_data_i),
            .regs     (aset[a])
        );

        alarm_matcher u_match (
            .regs (aset[a]),
            .cal  (cal),
            .hit  (hit_vec[a])
        );

        always_comb begin
            en_any_vec[a] = 1'b0;
            for (int f = 0; f < NUM_FIELDS; f++) begin
                en_any_vec[a] = en_any_vec[a] | aset[a][f].en;
            end
        end
    end

    alarm_flag_ctrl #(.N(NUM_ALARMS)) u_flags (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick_i),
        .hit      (hit_vec),
        .rd_start (sr_rd_start_i),
        .rd_done  (sr_rd_done_i),
        .flags    (flag_vec)
    );

    always_comb begin
        st.bat  = bat_i;
        st.al1  = flag_vec[1];
        st.al0  = flag_vec[0];
        st.pad  = 2'b00;
        st.rwel = rwel_i;
        st.wel  = wel_i;
        st.rtcf = rtcf_i;
    end

    assign al0_o    = flag_vec[0];
    assign al1_o    = flag_vec[1];
    assign status_o = st;
endmodule

// File: rtl/cal_alarm_match_chk.sv
module cal_alarm_match_chk (
    input logic       clk,
    input logic       rst,
    input logic       tick_i,
    input logic       sr_rd_done_i,
    input logic       al0_o,
    input logic       al1_o,
    input logic [7:0] status_o,
    input logic [1:0] hit_vec,
    input logic [1:0] en_any_vec
);
    assert_sticky0_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(al0_o) |-> $past(sr_rd_done_i));
    assert_sticky1_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(al1_o) |-> $past(sr_rd_done_i));
    assert_only_on_tick0_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(al0_o) |-> $past(tick_i));
    assert_only_on_tick1_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(al1_o) |-> $past(tick_i));
    assert_hit_lands0_R11: assert property (@(posedge clk) disable iff (rst)
        (tick_i && hit_vec[0]) |=> al0_o);
    assert_hit_lands1_R11: assert property (@(posedge clk) disable iff (rst)
        (tick_i && hit_vec[1]) |=> al1_o);
    assert_no_enable0_R4: assert property (@(posedge clk) disable iff (rst)
        (!en_any_vec[0] && !al0_o) |=> !$rose(al0_o));
    assert_no_enable1_R4: assert property (@(posedge clk) disable iff (rst)
        (!en_any_vec[1] && !al1_o) |=> !$rose(al1_o));
    assert_status_pad_R9: assert property (@(posedge clk) disable iff (rst)
        status_o[4:3] == 2'b00);
    assert_status_flags_R9: assert property (@(posedge clk) disable iff (rst)
        (status_o[6] == al1_o) && (status_o[5] == al0_o));
endmodule

bind cal_alarm_match cal_alarm_match_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .tick_i       (tick_i),
    .sr_rd_done_i (sr_rd_done_i),
    .al0_o        (al0_o),
    .al1_o        (al1_o),
    .status_o     (status_o),
    .hit_vec      (hit_vec),
    .en_any_vec   (en_any_vec)
);

// File: tb/cal_alarm_match_test.sv
`timescale 1ns/1ps
module cal_alarm_match_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_i = 1'b0;
    logic [7:0] cal_sec_i = '0, cal_min_i = '0, cal_hour_i = '0;
    logic [7:0] cal_date_i = '0, cal_mon_i = '0, cal_dow_i = '0;
    logic       wr_en_i = 1'b0, wr_alarm_i = 1'b0;
    logic [2:0] wr_field_i = '0;
    logic [7:0] wr_data_i = '0;
    logic       sr_rd_start_i = 1'b0, sr_rd_done_i = 1'b0;
    logic       bat_i = 1'b0, rwel_i = 1'b0, wel_i = 1'b0, rtcf_i = 1'b0;
    logic       al0_o, al1_o;
    logic [7:0] status_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [7:0] m_reg [2][6];
    logic [1:0] m_fl, m_snap;
    logic       m_open;

    always #2.5 clk = ~clk;

    cal_alarm_match uut (.*);

    function automatic logic [6:0] calv(int f);
        case (f)
            0: return cal_sec_i[6:0];
            1: return cal_min_i[6:0];
            2: return cal_hour_i[6:0];
            3: return cal_date_i[6:0];
            4: return cal_mon_i[6:0];
            default: return cal_dow_i[6:0];
        endcase
    endfunction

    function automatic logic mhit(int a);
        logic any = 1'b0;
        logic ok  = 1'b1;
        for (int f = 0; f < 6; f++) begin
            if (m_reg[a][f][7]) begin
                any = 1'b1;
                if (m_reg[a][f][6:0] != calv(f)) ok = 1'b0;
            end
        end
        return any && ok;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int a = 0; a < 2; a++)
            for (int f = 0; f < 6; f++) m_reg[a][f] = '0;
        m_fl = '0; m_snap = '0; m_open = 1'b0;
    endtask

    // One clock: predict from current inputs, clock, compare, drop pulses.
    task automatic cycle(string tag);
        logic [1:0] set, snap_eff, clr;
        logic       open_eff;
        set      = tick_i ? {mhit(1), mhit(0)} : 2'b00;
        snap_eff = sr_rd_start_i ? m_fl : m_snap;
        open_eff = sr_rd_start_i | m_open;
        clr      = (sr_rd_done_i && open_eff) ? snap_eff : 2'b00;
        @(posedge clk);
        #1;
        m_fl   = (m_fl & ~clr) | set;
        m_snap = sr_rd_done_i ? 2'b00 : snap_eff;
        m_open = open_eff & ~sr_rd_done_i;
        if (wr_en_i && wr_field_i < 3'd6) m_reg[wr_alarm_i][wr_field_i] = wr_data_i;
        check({tag, " flags"}, {30'd0, al1_o, al0_o}, {30'd0, m_fl});
        check({tag, " R9 status"}, {24'd0, status_o},
              {24'd0, bat_i, m_fl[1], m_fl[0], 2'b00, rwel_i, wel_i, rtcf_i});
        tick_i = 1'b0; wr_en_i = 1'b0; sr_rd_start_i = 1'b0; sr_rd_done_i = 1'b0;
    endtask

    task automatic wr(logic a, logic [2:0] f, logic [7:0] d, string tag);
        wr_en_i = 1'b1; wr_alarm_i = a; wr_field_i = f; wr_data_i = d;
        cycle(tag);
    endtask

    task automatic set_cal(logic [7:0] s, logic [7:0] mi, logic [7:0] h,
                           logic [7:0] dt, logic [7:0] mo, logic [7:0] dw);
        cal_sec_i = s; cal_min_i = mi; cal_hour_i = h;
        cal_date_i = dt; cal_mon_i = mo; cal_dow_i = dw;
    endtask

    task automatic clear_all(string tag);
        sr_rd_start_i = 1'b1; cycle(tag);
        sr_rd_done_i = 1'b1;  cycle(tag);
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        bat_i = 1'b1; rtcf_i = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1: reset state, status pass-through
        check("R1 flags after reset", {30'd0, al1_o, al0_o}, 32'd0);
        check("R1 R9 status after reset", {24'd0, status_o}, 32'h81);

        // R4: everything disabled, calendar equals stored zero values
        set_cal(0, 0, 0, 0, 0, 0);
        tick_i = 1'b1; cycle("R4 all disabled");
        check("R4 no flag", {31'd0, al0_o}, 32'd0);

        // R2/R3: minutes-only alarm 0 at 0x30
        wr(1'b0, 3'd1, 8'hB0, "R2 write");
        set_cal(8'h12, 8'h31, 8'h05, 8'h01, 8'h01, 8'h02);
        tick_i = 1'b1; cycle("R3 mismatch");
        check("R3 mismatch no flag", {31'd0, al0_o}, 32'd0);
        cal_min_i = 8'h30;
        cycle("R7 no tick");
        check("R7 match without tick", {31'd0, al0_o}, 32'd0);
        tick_i = 1'b1; cycle("R3 match");
        check("R3 enabled field match", {31'd0, al0_o}, 32'd1);
        check("R12 alarm1 idle", {31'd0, al1_o}, 32'd0);
        repeat (3) cycle("R8 hold");
        check("R8 flag held", {31'd0, al0_o}, 32'd1);

        // R5/R6: alarm 1 hour 08 enabled, year written with enable set
        wr(1'b1, 3'd2, 8'h88, "R2 write hour");
        wr(1'b1, 3'd6, 8'hFF, "R5 write year");
        wr(1'b1, 3'd7, 8'hFF, "R5 write unused");
        set_cal(8'h00, 8'h00, 8'h88, 8'h15, 8'h07, 8'h03);
        tick_i = 1'b1; cycle("R6 hour mode bit");
        check("R6 R5 hour matched ignoring bit7 and year", {31'd0, al1_o}, 32'd1);

        // R10/R11: read opens with only AL1 set ... wait al0 also set
        clear_all("R10 clear");
        check("R10 both cleared", {30'd0, al1_o, al0_o}, 32'd0);
        set_cal(8'h00, 8'h30, 8'h08, 8'h15, 8'h07, 8'h03);
        tick_i = 1'b1; cycle("R12 both");
        check("R12 both set", {30'd0, al1_o, al0_o}, 32'd3);
        clear_all("R10 clear2");
        cal_min_i = 8'h30; cal_hour_i = 8'h01;
        tick_i = 1'b1; cycle("R12 al0 only");
        sr_rd_start_i = 1'b1; cycle("R10 start");
        cal_hour_i = 8'h08; cal_min_i = 8'h11;
        tick_i = 1'b1; cycle("R11 fire during read");
        check("R11 al1 set during read", {30'd0, al1_o, al0_o}, 32'd3);
        sr_rd_done_i = 1'b1; cycle("R10 done");
        check("R10 R11 only snapshot cleared", {30'd0, al1_o, al0_o}, 32'd2);
        sr_rd_done_i = 1'b1; tick_i = 1'b1; cycle("R10 done without read");
        check("R10 stray done no clear", {30'd0, al1_o, al0_o}, 32'd2);

        // Random phase
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = int'($urandom_range(0, 99));
            bat_i = 1'($urandom); rwel_i = 1'($urandom);
            wel_i = 1'($urandom); rtcf_i = 1'($urandom);
            if (r < 25) begin
                wr_en_i = 1'b1; wr_alarm_i = 1'($urandom);
                wr_field_i = 3'($urandom);
                wr_data_i = {($urandom_range(0, 9) < 3) ? 1'b1 : 1'b0, 7'($urandom_range(0, 3))};
            end
            if (r >= 20 && r < 60) begin
                int a;
                a = int'($urandom_range(0, 1));
                tick_i = 1'b1;
                set_cal({1'($urandom), ($urandom_range(0,1) != 0) ? m_reg[a][0][6:0] : 7'($urandom_range(0,3))},
                        {1'b0, ($urandom_range(0,3) != 0) ? m_reg[a][1][6:0] : 7'($urandom_range(0,3))},
                        {1'($urandom), ($urandom_range(0,3) != 0) ? m_reg[a][2][6:0] : 7'($urandom_range(0,3))},
                        {1'b0, ($urandom_range(0,3) != 0) ? m_reg[a][3][6:0] : 7'($urandom_range(0,3))},
                        {1'b0, ($urandom_range(0,3) != 0) ? m_reg[a][4][6:0] : 7'($urandom_range(0,3))},
                        {1'b0, ($urandom_range(0,3) != 0) ? m_reg[a][5][6:0] : 7'($urandom_range(0,3))});
            end
            if ($urandom_range(0, 9) == 0) sr_rd_start_i = 1'b1;
            if ($urandom_range(0, 9) == 0) sr_rd_done_i = 1'b1;
            cycle("R8 R12 random");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule